// File: doc/BRIEF.md
# Serial EEPROM Status Register Write Controller

This block is the device-side control logic that a serial EEPROM uses for its status register. It listens on a mode-0 SPI slave port: chip select, serial clock, serial data in and serial data out, plus an active-low write-protect pin. It decodes three one-byte commands. The set-write-enable command (0x06) arms a write-enable flag. The read-status command (0x05) streams the status byte back. The write-status command (0x01) is followed by one data byte and loads the two protection bits.

All SPI pins are brought into the system clock domain through a synchronizer chain. The frame logic runs on the detected edges of the synchronized serial clock. A write-status frame is accepted only when all of the following hold: the write-enable flag is set, no timed write is running, the write-protect pin stayed high for the whole selected period, and chip select rose after exactly sixteen clocked bits. An accepted write starts a busy period of a programmable number of system clocks. When the busy period ends, the new protection bits are committed and the write-enable flag is cleared.

The status byte has this layout: bit 0 is busy (write in progress), bit 1 is the write-enable flag, bits 3:2 are the protection bits, and bits 7:4 are always zero. Serial data is sampled on rising serial-clock edges, most significant bit first. Output bits change on falling edges.

Top module: `eeprom_sr_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00 and the data-out enable is low.
- R2: The data-out enable follows the synchronized chip select: it is high exactly while chip select is low, delayed by the synchronizer depth.
- R3: A read-status frame (opcode 0x05) returns the status byte MSB first, repeated for every further byte clocked out. Bit 0 is busy, bit 1 is write-enable, bits 3:2 are protection, and bits 7:4 read 0.
- R4: The set-write-enable command (0x06) sets the write-enable bit only when chip select rises after exactly 8 clocked bits. With 7 or 9 bits it has no effect.
- R5: The set-write-enable command has no effect while a timed write is running.
- R6: A write-status frame (0x01 followed by a data byte) is accepted only if the write-enable bit is 1, no timed write is running, and chip select rises after exactly 16 clocked bits. Otherwise the status is unchanged.
- R7: A write-status frame is rejected if write-protect is low at any time while chip select is low. Write-protect going low while the device is deselected has no effect.
- R8: An accepted write-status frame sets the busy bit for WRITE_CYCLES system clocks. The status stays readable during that time.
- R9: The protection bits take data bits 3:2 only when the busy period ends, and the write-enable bit is cleared at that moment. Data bits 7:4, 1 and 0 never reach the status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock from the host |
| spi_mosi | input | 1 | Serial data from the host |
| wp_n | input | 1 | Write protect, active low |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Output enable for spi_miso (low means high impedance) |

## Verification
A wrong bit count or latched opcode shows at the next chip-select rise. A command is then wrongly accepted or dropped, and the next read-status frame exposes it within one byte. A wrong busy timer or pending-value register stays hidden until the busy period ends. It then appears as protection bits or a write-enable bit that do not match the reference, or as a busy bit seen too early or too late by a read issued inside the window. A wrong output-enable path differs from the reference within the synchronizer depth, on the same clock as the chip-select change.

// File: rtl/sr_pkg.sv
package sr_pkg;

  localparam logic [7:0] OP_SET_WEL  = 8'h06;
  localparam logic [7:0] OP_RD_STAT  = 8'h05;
  localparam logic [7:0] OP_WR_STAT  = 8'h01;

  localparam int OP_BITS      = 8;
  localparam int WR_FRAME_BITS = 16;
  localparam int BIT_CNT_W    = $clog2(WR_FRAME_BITS + 2);
  localparam int STATUS_W     = 8;

  typedef struct packed {
    logic [1:0] prot;
    logic       wel;
    logic       busy;
  } sr_state_t;

  function automatic logic [STATUS_W-1:0] pack_status(input sr_state_t s);
    pack_status = {4'b0000, s.prot, s.wel, s.busy};
  endfunction

endpackage

// File: rtl/sr_sync.sv
module sr_sync #(
  parameter int                 WIDTH   = 4,
  parameter int                 STAGES  = 2,
  parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] r_q;
    logic [WIDTH-1:0] r_d;
    if (s == 0) begin : g_first
      assign r_d = d;
    end else begin : g_chain
      assign r_d = g_stage[s-1].r_q;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) r_q <= RST_VAL;
      else        r_q <= r_d;
    end
  end

  assign q = g_stage[STAGES-1].r_q;

endmodule

// File: rtl/sr_frame.sv
module sr_frame
  import sr_pkg::*;
#(
  parameter int CNT_W = BIT_CNT_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_n_s,
  input  logic                sck_s,
  input  logic                mosi_s,
  input  logic                wp_n_s,
  input  logic [STATUS_W-1:0] status_byte,
  output logic                frame_end,
  output logic [CNT_W-1:0]    frame_bits,
  output logic [15:0]         frame_word,
  output logic                frame_wp_ok,
  output logic                miso_bit
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic                sck_prev_q, sck_prev_d;
  logic                cs_prev_q,  cs_prev_d;
  logic [CNT_W-1:0]    bits_q,     bits_d;
  logic [15:0]         word_q,     word_d;
  logic                wp_low_q,   wp_low_d;
  logic [7:0]          op_q,       op_d;
  logic                op_vld_q,   op_vld_d;
  logic [2:0]          phase_q,    phase_d;
  logic [STATUS_W-1:0] out_q,      out_d;

  logic sck_rise, sck_fall, selected;

  assign selected = ~cs_n_s;
  assign sck_rise = selected &  sck_s & ~sck_prev_q;
  assign sck_fall = selected & ~sck_s &  sck_prev_q;

  always_comb begin
    sck_prev_d = sck_s;
    cs_prev_d  = cs_n_s;
    bits_d     = bits_q;
    word_d     = word_q;
    wp_low_d   = wp_low_q;
    op_d       = op_q;
    op_vld_d   = op_vld_q;
    phase_d    = phase_q;
    out_d      = out_q;
    if (!selected) begin
      bits_d   = '0;
      wp_low_d = 1'b0;
      op_vld_d = 1'b0;
      phase_d  = '0;
      out_d    = '0;
    end else begin
      wp_low_d = wp_low_q | ~wp_n_s;
      if (sck_rise) begin
        word_d  = {word_q[14:0], mosi_s};
        phase_d = phase_q + 3'd1;
        if (bits_q != CNT_MAX) bits_d = bits_q + 1'b1;
        if (!op_vld_q && phase_q == 3'd7) begin
          op_d     = {word_q[6:0], mosi_s};
          op_vld_d = 1'b1;
        end
      end
      if (sck_fall && op_vld_q && op_q == OP_RD_STAT) begin
        if (phase_q == 3'd0) out_d = status_byte;
        else                 out_d = {out_q[STATUS_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_prev_q <= 1'b0;
      cs_prev_q  <= 1'b1;
      bits_q     <= '0;
      word_q     <= '0;
      wp_low_q   <= 1'b0;
      op_q       <= '0;
      op_vld_q   <= 1'b0;
      phase_q    <= '0;
      out_q      <= '0;
    end else begin
      sck_prev_q <= sck_prev_d;
      cs_prev_q  <= cs_prev_d;
      bits_q     <= bits_d;
      word_q     <= word_d;
      wp_low_q   <= wp_low_d;
      op_q       <= op_d;
      op_vld_q   <= op_vld_d;
      phase_q    <= phase_d;
      out_q      <= out_d;
    end
  end

  assign frame_end   = cs_n_s & ~cs_prev_q;
  assign frame_bits  = bits_q;
  assign frame_word  = word_q;
  assign frame_wp_ok = ~wp_low_q;
  assign miso_bit    = out_q[STATUS_W-1];

  // R6: the bit count never goes down inside one selected period
  assert_bits_monotonic_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_s && !cs_prev_q) |-> (bits_q >= $past(bits_q)));

  // R3: once the opcode is latched it holds for the rest of the frame
  assert_opcode_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_vld_q && $past(op_vld_q)) |-> $stable(op_q));

endmodule

// File: rtl/sr_status.sv
module sr_status
  import sr_pkg::*;
#(
  parameter int WRITE_CYCLES = 50000,
  parameter int CNT_W        = BIT_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_end,
  input  logic [CNT_W-1:0] frame_bits,
  input  logic [15:0]      frame_word,
  input  logic             frame_wp_ok,
  output sr_state_t        state
);

  localparam int            TMR_W = (WRITE_CYCLES > 2) ? $clog2(WRITE_CYCLES) : 1;
  localparam logic [TMR_W-1:0] TMR_LOAD = TMR_W'(WRITE_CYCLES - 1);

  logic             busy_q, busy_d;
  logic             wel_q,  wel_d;
  logic [1:0]       prot_q, prot_d;
  logic [1:0]       pend_q, pend_d;
  logic [TMR_W-1:0] tmr_q,  tmr_d;

  logic take_wel, take_write, tmr_done;

  assign take_wel   = frame_end && !busy_q &&
                      frame_bits == CNT_W'(OP_BITS) &&
                      frame_word[7:0] == OP_SET_WEL;
  assign take_write = frame_end && !busy_q && wel_q && frame_wp_ok &&
                      frame_bits == CNT_W'(WR_FRAME_BITS) &&
                      frame_word[15:8] == OP_WR_STAT;
  assign tmr_done   = busy_q && tmr_q == '0;

  always_comb begin
    busy_d = busy_q;
    wel_d  = wel_q;
    prot_d = prot_q;
    pend_d = pend_q;
    tmr_d  = tmr_q;
    if (busy_q) begin
      if (tmr_done) begin
        busy_d = 1'b0;
        wel_d  = 1'b0;
        prot_d = pend_q;
      end else begin
        tmr_d = tmr_q - 1'b1;
      end
    end else begin
      if (take_wel) wel_d = 1'b1;
      if (take_write) begin
        busy_d = 1'b1;
        tmr_d  = TMR_LOAD;
        pend_d = frame_word[3:2];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      wel_q  <= 1'b0;
      prot_q <= '0;
      pend_q <= '0;
      tmr_q  <= '0;
    end else begin
      busy_q <= busy_d;
      wel_q  <= wel_d;
      prot_q <= prot_d;
      pend_q <= pend_d;
      tmr_q  <= tmr_d;
    end
  end

  assign state = '{prot: prot_q, wel: wel_q, busy: busy_q};

  assert_start_needs_wel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(wel_q));

  assert_wel_only_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel_q) |-> !$past(busy_q));

  assert_prot_only_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(busy_q) |-> $stable(prot_q));

  assert_wel_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> !wel_q);

  assert_busy_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && tmr_q != '0) |=> busy_q);

endmodule

// File: rtl/eeprom_sr_ctrl.sv
module eeprom_sr_ctrl
  import sr_pkg::*;
#(
  parameter int WRITE_CYCLES = 50000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_cs_n,
  input  logic spi_sck,
  input  logic spi_mosi,
  input  logic wp_n,
  output logic spi_miso,
  output logic spi_miso_oe
);

  localparam int              PIN_W       = 4;
  localparam logic [PIN_W-1:0] PIN_IDLE   = 4'b1001;

  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  logic [PIN_W-1:0] pins_raw, pins_s;
  logic cs_n_s, sck_s, mosi_s, wp_n_s;

  assign pins_raw = {spi_cs_n, spi_sck, spi_mosi, wp_n};

  sr_sync #(
    .WIDTH   (PIN_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (PIN_IDLE)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pins_raw),
    .q     (pins_s)
  );

  assign {cs_n_s, sck_s, mosi_s, wp_n_s} = pins_s;

  sr_state_t           state;
  logic [STATUS_W-1:0] status_byte;
  logic                frame_end, frame_wp_ok, miso_bit;
  logic [BIT_CNT_W-1:0] frame_bits;
  logic [15:0]         frame_word;

  assign status_byte = pack_status(state);

  sr_frame #(.CNT_W(BIT_CNT_W)) u_frame (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .cs_n_s      (cs_n_s),
    .sck_s       (sck_s),
    .mosi_s      (mosi_s),
    .wp_n_s      (wp_n_s),
    .status_byte (status_byte),
    .frame_end   (frame_end),
    .frame_bits  (frame_bits),
    .frame_word  (frame_word),
    .frame_wp_ok (frame_wp_ok),
    .miso_bit    (miso_bit)
  );

  sr_status #(
    .WRITE_CYCLES (WRITE_CYCLES),
    .CNT_W        (BIT_CNT_W)
  ) u_status (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .frame_end   (frame_end),
    .frame_bits  (frame_bits),
    .frame_word  (frame_word),
    .frame_wp_ok (frame_wp_ok),
    .state       (state)
  );

  assign spi_miso_oe = ~cs_n_s;
  assign spi_miso    = cs_n_s ? 1'b0 : miso_bit;

  // R7: a write can only start at the end of a frame that had write-protect high
  assert_write_start_clean_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(state.busy) |-> ($past(frame_end) && $past(frame_wp_ok)));

endmodule

// File: tb/eeprom_sr_ctrl_tb_top.sv
module eeprom_sr_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;
  localparam int WCYC       = 800;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, wp_n = 1'b1;
  logic miso, miso_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_sr_ctrl #(.WRITE_CYCLES(WCYC), .SYNC_STAGES(2)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .spi_cs_n    (cs_n),
    .spi_sck     (sck),
    .spi_mosi    (mosi),
    .wp_n        (wp_n),
    .spi_miso    (miso),
    .spi_miso_oe (miso_oe)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // behavioural reference state
  bit       m_wel, m_busy;
  bit [1:0] m_prot, m_pend;
  logic [23:0] rxbuf;
  logic cs_seen = 1'b1;

  // R2: compare output enable to the delayed chip select on every clock
  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (miso_oe !== ~cs_seen) begin
        fails++;
        $display("FAIL R2 oe: got %b expected %b", miso_oe, ~cs_seen);
      end
      cs_seen = cs_n;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic check8(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic spi_xfer(input logic [23:0] tx, input int n, input int wp_lo, input int wp_hi);
    tick(1);
    cs_n = 1'b0;
    tick(HALF);
    for (int i = 0; i < n; i++) begin
      mosi = tx[n-1-i];
      wp_n = !(i >= wp_lo && i < wp_hi);
      tick(HALF);
      rxbuf = {rxbuf[22:0], miso};
      sck = 1'b1;
      tick(HALF);
      sck = 1'b0;
    end
    tick(HALF);
    wp_n = 1'b1;
    cs_n = 1'b1;
    tick(2*HALF);
  endtask

  function automatic logic [7:0] exp_status();
    return {4'b0000, m_prot, m_wel, m_busy};
  endfunction

  task automatic do_wren(input int n);
    logic [23:0] tx;
    if (n == 8)      tx = 24'h000006;
    else if (n == 7) tx = 24'h000003;
    else             tx = 24'h00000C;
    spi_xfer(tx, n, 0, 0);
    if (n == 8 && !m_busy) m_wel = 1'b1;
  endtask

  task automatic do_wrsr(input logic [7:0] data, input int n, input int wp_lo, input int wp_hi);
    logic [23:0] tx;
    if (n == 17)      tx = {7'd0, 8'h01, data, 1'b0};
    else if (n == 15) tx = {9'd0, 8'h01, data[7:1]};
    else              tx = {8'd0, 8'h01, data};
    spi_xfer(tx, n, wp_lo, wp_hi);
    if (n == 16 && m_wel && !m_busy && wp_lo >= wp_hi) begin
      m_busy = 1'b1;
      m_pend = data[3:2];
    end
  endtask

  task automatic settle();
    tick(WCYC + 40);
    if (m_busy) begin
      m_busy = 1'b0;
      m_wel  = 1'b0;
      m_prot = m_pend;
    end
  endtask

  task automatic read_status(input string tag);
    spi_xfer(24'h000500, 16, 0, 0);
    check8(tag, rxbuf[7:0], exp_status());
  endtask

  initial begin
    m_wel = 0; m_busy = 0; m_prot = 0; m_pend = 0; rxbuf = '0;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    checks++;
    if (miso_oe !== 1'b0) begin
      fails++;
      $display("FAIL R1 oe after reset: got %b expected 0", miso_oe);
    end
    read_status("R1 reset status");

    do_wrsr(8'h0C, 16, 0, 0);
    read_status("R6 write without enable");

    do_wren(7);
    read_status("R4 enable with 7 bits");
    do_wren(9);
    read_status("R4 enable with 9 bits");
    do_wren(8);
    read_status("R4 enable with 8 bits");

    do_wrsr(8'h0C, 17, 0, 0);
    read_status("R6 write with 17 bits");
    do_wrsr(8'h0C, 15, 0, 0);
    read_status("R6 write with 15 bits");

    do_wrsr(8'h0C, 16, 3, 5);
    read_status("R7 protect low in opcode");
    do_wrsr(8'h0C, 16, 12, 14);
    read_status("R7 protect low in data");

    tick(4); wp_n = 1'b0; tick(20); wp_n = 1'b1; tick(20);
    do_wrsr(8'hFF, 16, 0, 0);
    read_status("R8 busy visible, R9 old protect held");
    do_wren(8);
    settle();
    read_status("R9 commit, R5 enable ignored while busy, R3 upper bits zero");

    do_wren(8);
    read_status("R4 enable again");
    do_wrsr(8'h04, 16, 0, 0);
    do_wrsr(8'h08, 16, 0, 0);
    spi_xfer(24'h050000, 24, 0, 0);
    check8("R3 repeated byte 1 while busy", rxbuf[15:8], exp_status());
    check8("R3 repeated byte 2 while busy", rxbuf[7:0], exp_status());
    settle();
    read_status("R6 write during busy rejected, R9 commit");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule